// File: doc/BRIEF.md
# Egress Packet Assembler with Dual-Queue Arbitration

This block drains outgoing transaction-layer packets that another clock domain has staged in two shared buffers. The first buffer holds 128-bit header entries and the second holds 128-bit payload entries. Each entry carries four parity bits, one for each 32-bit dword. Both buffers are split between a request queue and a completion queue. The writer owns a Gray-coded header write pointer for each queue and a payload write count for each queue. The block returns a Gray-coded header read pointer and a Gray-coded payload read pointer for each queue.

The block gives the two queues strictly alternating turns. On a turn where the queue holds a header, the block reads that header and checks its parity. It then sends the packet one byte per cycle on the matching output port: a start marker first, then the header bytes, then any payload bytes. The control code on the last byte reports whether a payload parity error occurred. A corrupted header is dropped. Each parity error raises a one-cycle drain request. While the drain input is high the block does nothing and holds its state.

Top module: `egtx_builder`

## Requirements
- R1: After reset every valid, start, last, error and drain-request output is 0, and all four read pointers are zero.
- R2: Turns alternate strictly between request and completion. Each turn takes one cycle and examines one queue even when that queue is empty. With only the request queue busy, back-to-back packets therefore show exactly three cycles from one packet's last byte to the next packet's start byte.
- R3: A queue is busy when its Gray header read pointer differs from the writer's Gray header write pointer. The header read pointer advances by one for each header consumed, and the published Gray value changes by at most one bit per cycle.
- R4: A request header is read at header-buffer address {1, index}, which is the index ORed with 0x20 for the default width. A completion header is read at {0, index}.
- R5: A packet is sent on exactly one port (request or completion). It starts with byte 0xFB with tx_start set. The header bytes follow, most significant byte first (bits 127:120 first). There are 16 header bytes if header bit 125 is 1 and 12 if it is 0.
- R6: A payload follows the header when header bit 126 is 1. Its length L is header bits 105:96, in dwords. The payload is L[9:2] full 16-byte entries, plus one entry of L[1:0]*4 bytes when L[1:0] is nonzero. Request payload is read at data address {1, index} and completion payload at {0, index}. The Gray payload read pointer advances after each entry is consumed.
- R7: While a queue's payload read count equals the writer's payload count for that queue, packet output stalls with no valid bytes, and then resumes without losing any byte.
- R8: On a header parity mismatch the block sends no packet and pulses hdr_perr and drain_req for one cycle. The header read pointer still advances.
- R9: tx_ctrl is 0x02 on the last byte of a clean packet. If a payload entry has a parity mismatch and the poisoned bit (header bit 110) is 0, the packet is still sent in full, its last byte carries 0x12, and dat_perr and drain_req pulse. If the poisoned bit is 1, payload parity errors are ignored.
- R10: Parity bit 128+i of an entry is valid when dword i (bits 32i+31:32i) together with that bit holds an odd number of ones.
- R11: While drain_i is 1, no queue is examined, no byte is sent and all read pointers hold. Service resumes when drain_i returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drain_i | input | 1 | Freeze all service while high |
| req_hdr_wptr_g | input | HI_W+1 | Writer's Gray header write pointer, request queue |
| cpl_hdr_wptr_g | input | HI_W+1 | Writer's Gray header write pointer, completion queue |
| req_dat_wcnt | input | DI_W+1 | Writer's payload entry count, request queue |
| cpl_dat_wcnt | input | DI_W+1 | Writer's payload entry count, completion queue |
| req_hdr_rptr_g | output | HI_W+1 | Gray header read pointer, request queue |
| cpl_hdr_rptr_g | output | HI_W+1 | Gray header read pointer, completion queue |
| req_dat_rptr_g | output | DI_W+1 | Gray payload read pointer, request queue |
| cpl_dat_rptr_g | output | DI_W+1 | Gray payload read pointer, completion queue |
| hbuf_addr | output | HI_W+1 | Header buffer read address |
| hbuf_rdata | input | 132 | Header entry: parity 131:128, data 127:0 |
| dbuf_addr | output | DI_W+1 | Payload buffer read address |
| dbuf_rdata | input | 132 | Payload entry: parity 131:128, data 127:0 |
| req_tx_valid | output | 1 | Byte valid on the request port |
| cpl_tx_valid | output | 1 | Byte valid on the completion port |
| tx_byte | output | 8 | Byte being sent |
| tx_start | output | 1 | Byte is the start marker |
| tx_last | output | 1 | Byte is the last byte of the packet |
| tx_ctrl | output | 8 | Packet control code, valid with tx_last |
| hdr_perr | output | 1 | Header parity error pulse |
| dat_perr | output | 1 | Payload parity error pulse |
| drain_req | output | 1 | Drain request pulse on any parity error |

## Verification
The bench drives packets whose last payload entry is partial, so a design that rounds the tail up to a full entry sends extra bytes. It fills both halves of each buffer at once, so a wrong split bit returns the other queue's bytes. It runs a single busy queue, where a design that skips the empty turn shortens the gap between packets to two cycles. A corrupted header must disappear without stalling the pointer. A corrupted payload entry must still reach the port, tagged, unless the poisoned bit is set. A packet that stalls for payload, or that is held under drain, must come out complete once the block is released. A run of headers past the buffer depth checks that the Gray pointers wrap.

// File: rtl/egtx_pkg.sv
package egtx_pkg;
  localparam int DATA_W  = 128;
  localparam int DW_CNT  = 4;
  localparam int ENTRY_W = DATA_W + DW_CNT;

  localparam logic [7:0] START_MARK = 8'hFB;
  localparam logic [7:0] CTRL_OK    = 8'h02;
  localparam logic [7:0] CTRL_BAD   = 8'h12;

  typedef enum logic [2:0] {
    ST_ARB, ST_SOP, ST_HDR, ST_DFETCH, ST_DBYTE
  } tx_state_e;

  // odd parity over one dword: the stored bit makes the count of ones odd
  function automatic logic dword_par(logic [31:0] d);
    return ~^d;
  endfunction

  function automatic logic [4:0] hdr_bytes(logic [DATA_W-1:0] h);
    return h[125] ? 5'd16 : 5'd12;
  endfunction

  function automatic logic [9:0] pay_len(logic [DATA_W-1:0] h);
    return h[105:96];
  endfunction

  function automatic logic [8:0] pay_entries(logic [9:0] len);
    return {1'b0, len[9:2]} + {8'd0, |len[1:0]};
  endfunction

  function automatic logic [4:0] tail_bytes(logic [9:0] len);
    return {1'b0, len[1:0], 2'b00};
  endfunction

  // byte k of an entry, k = 0 is bits 127:120
  function automatic logic [7:0] pick_byte(logic [DATA_W-1:0] d, logic [3:0] k);
    logic [DATA_W-1:0] s;
    s = d >> {~k, 3'b000};
    return s[7:0];
  endfunction
endpackage

// File: rtl/egtx_par_chk.sv
module egtx_par_chk
  import egtx_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output logic               bad
);
  logic [DW_CNT-1:0] mis;
  for (genvar i = 0; i < DW_CNT; i++) begin : g_dw
    assign mis[i] = entry[DATA_W+i] != dword_par(entry[32*i +: 32]);
  end
  assign bad = |mis;
endmodule

// File: rtl/egtx_ptr.sv
module egtx_ptr #(
  parameter int W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  output logic [W:0] bin,
  output logic [W:0] gray
);
  always_ff @(posedge clk) begin
    if (!rst_n)   bin <= '0;
    else if (inc) bin <= bin + (W+1)'(1);
  end
  assign gray = bin ^ (bin >> 1);
endmodule

// File: rtl/egtx_builder.sv
module egtx_builder
  import egtx_pkg::*;
#(
  parameter int HI_W = 5,
  parameter int DI_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                drain_i,
  input  logic [HI_W:0]       req_hdr_wptr_g,
  input  logic [HI_W:0]       cpl_hdr_wptr_g,
  input  logic [DI_W:0]       req_dat_wcnt,
  input  logic [DI_W:0]       cpl_dat_wcnt,
  output logic [HI_W:0]       req_hdr_rptr_g,
  output logic [HI_W:0]       cpl_hdr_rptr_g,
  output logic [DI_W:0]       req_dat_rptr_g,
  output logic [DI_W:0]       cpl_dat_rptr_g,
  output logic [HI_W:0]       hbuf_addr,
  input  logic [ENTRY_W-1:0]  hbuf_rdata,
  output logic [DI_W:0]       dbuf_addr,
  input  logic [ENTRY_W-1:0]  dbuf_rdata,
  output logic                req_tx_valid,
  output logic                cpl_tx_valid,
  output logic [7:0]          tx_byte,
  output logic                tx_start,
  output logic                tx_last,
  output logic [7:0]          tx_ctrl,
  output logic                hdr_perr,
  output logic                dat_perr,
  output logic                drain_req
);
  tx_state_e          state;
  logic               turn_cpl, cur_cpl, perr_seen;
  logic [DATA_W-1:0]  hdr_q, ent_q;
  logic [3:0]         bcnt;
  logic [4:0]         blen;
  logic [8:0]         ents_left;

  logic [HI_W:0] rh_bin, ch_bin;
  logic [DI_W:0] rd_bin, cd_bin;
  logic          run, q_busy, hdr_bad, dat_bad, d_avail;
  logic          hdr_take, dat_take, dat_err;
  logic          last_hdr_byte, last_dat_byte, emit;
  logic [4:0]    hlen;
  logic [9:0]    cur_len;

  // read pointers, one instance per queue and buffer
  egtx_ptr #(.W(HI_W)) u_rh (.clk, .rst_n, .inc(hdr_take && !turn_cpl), .bin(rh_bin), .gray(req_hdr_rptr_g));
  egtx_ptr #(.W(HI_W)) u_ch (.clk, .rst_n, .inc(hdr_take &&  turn_cpl), .bin(ch_bin), .gray(cpl_hdr_rptr_g));
  egtx_ptr #(.W(DI_W)) u_rd (.clk, .rst_n, .inc(dat_take && !cur_cpl),  .bin(rd_bin), .gray(req_dat_rptr_g));
  egtx_ptr #(.W(DI_W)) u_cd (.clk, .rst_n, .inc(dat_take &&  cur_cpl),  .bin(cd_bin), .gray(cpl_dat_rptr_g));

  egtx_par_chk u_hpar (.entry(hbuf_rdata), .bad(hdr_bad));
  egtx_par_chk u_dpar (.entry(dbuf_rdata), .bad(dat_bad));

  assign run       = !drain_i;
  assign hbuf_addr = turn_cpl ? {1'b0, ch_bin[HI_W-1:0]} : {1'b1, rh_bin[HI_W-1:0]};
  assign q_busy    = turn_cpl ? (cpl_hdr_rptr_g != cpl_hdr_wptr_g)
                              : (req_hdr_rptr_g != req_hdr_wptr_g);
  assign hdr_take  = run && state == ST_ARB && q_busy;

  assign dbuf_addr = cur_cpl ? {1'b0, cd_bin[DI_W-1:0]} : {1'b1, rd_bin[DI_W-1:0]};
  assign d_avail   = cur_cpl ? (cd_bin != cpl_dat_wcnt) : (rd_bin != req_dat_wcnt);
  assign dat_take  = run && state == ST_DFETCH && d_avail;
  assign dat_err   = dat_take && dat_bad && !hdr_q[110];

  assign hdr_perr  = hdr_take && hdr_bad;
  assign dat_perr  = dat_err;
  assign drain_req = hdr_perr || dat_err;

  assign hlen    = hdr_bytes(hdr_q);
  assign cur_len = pay_len(hdr_q);

  assign last_hdr_byte = state == ST_HDR   && {1'b0, bcnt} == hlen - 5'd1 && ents_left == '0;
  assign last_dat_byte = state == ST_DBYTE && {1'b0, bcnt} == blen - 5'd1 && ents_left == '0;

  assign emit         = run && (state == ST_SOP || state == ST_HDR || state == ST_DBYTE);
  assign req_tx_valid = emit && !cur_cpl;
  assign cpl_tx_valid = emit &&  cur_cpl;
  assign tx_start     = run && state == ST_SOP;
  assign tx_last      = run && (last_hdr_byte || last_dat_byte);
  assign tx_ctrl      = tx_last ? (perr_seen ? CTRL_BAD : CTRL_OK) : 8'h00;

  always_comb begin
    unique case (state)
      ST_SOP:   tx_byte = START_MARK;
      ST_HDR:   tx_byte = pick_byte(hdr_q, bcnt);
      ST_DBYTE: tx_byte = pick_byte(ent_q, bcnt);
      default:  tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_ARB;
      turn_cpl  <= 1'b0;
      cur_cpl   <= 1'b0;
      perr_seen <= 1'b0;
      hdr_q     <= '0;
      ent_q     <= '0;
      bcnt      <= '0;
      blen      <= '0;
      ents_left <= '0;
    end else if (run) begin
      unique case (state)
        ST_ARB: begin
          turn_cpl <= !turn_cpl;
          if (q_busy && !hdr_bad) begin
            hdr_q     <= hbuf_rdata[DATA_W-1:0];
            cur_cpl   <= turn_cpl;
            perr_seen <= 1'b0;
            ents_left <= hbuf_rdata[126] ? pay_entries(pay_len(hbuf_rdata[DATA_W-1:0])) : '0;
            state     <= ST_SOP;
          end
        end
        ST_SOP: begin
          bcnt  <= '0;
          state <= ST_HDR;
        end
        ST_HDR: begin
          if ({1'b0, bcnt} == hlen - 5'd1) begin
            bcnt  <= '0;
            state <= (ents_left != '0) ? ST_DFETCH : ST_ARB;
          end else begin
            bcnt <= bcnt + 4'd1;
          end
        end
        ST_DFETCH: begin
          if (d_avail) begin
            ent_q     <= dbuf_rdata[DATA_W-1:0];
            blen      <= (ents_left == 9'd1 && cur_len[1:0] != 2'b00) ? tail_bytes(cur_len) : 5'd16;
            ents_left <= ents_left - 9'd1;
            perr_seen <= perr_seen || dat_err;
            bcnt      <= '0;
            state     <= ST_DBYTE;
          end
        end
        ST_DBYTE: begin
          if ({1'b0, bcnt} == blen - 5'd1) begin
            bcnt  <= '0;
            state <= (ents_left != '0) ? ST_DFETCH : ST_ARB;
          end else begin
            bcnt <= bcnt + 4'd1;
          end
        end
        default: state <= ST_ARB;
      endcase
    end
  end
endmodule

// File: rtl/egtx_builder_chk.sv
module egtx_builder_chk #(
  parameter int HI_W = 5,
  parameter int DI_W = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drain_i,
  input logic [HI_W:0] req_hdr_rptr_g,
  input logic [HI_W:0] cpl_hdr_rptr_g,
  input logic [DI_W:0] req_dat_rptr_g,
  input logic [DI_W:0] cpl_dat_rptr_g,
  input logic          req_tx_valid,
  input logic          cpl_tx_valid,
  input logic [7:0]    tx_byte,
  input logic          tx_start,
  input logic          tx_last,
  input logic [7:0]    tx_ctrl,
  input logic          hdr_perr,
  input logic          dat_perr,
  input logic          drain_req,
  input logic          hdr_take,
  input logic          dat_take
);
  p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_tx_valid && cpl_tx_valid));

  p_start_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (req_tx_valid || cpl_tx_valid) && tx_byte == 8'hFB);

  p_ctrl_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_ctrl == 8'h02 || tx_ctrl == 8'h12));

  p_hperr_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_perr |-> drain_req && hdr_take);

  p_hperr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_perr |=> !tx_start);

  p_dperr_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_perr |-> drain_req && dat_take);

  p_req_gray_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_hdr_rptr_g ^ $past(req_hdr_rptr_g)) <= 1);

  p_cpl_gray_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cpl_hdr_rptr_g ^ $past(cpl_hdr_rptr_g)) <= 1);

  p_hdr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_take |=> $stable(req_hdr_rptr_g) && $stable(cpl_hdr_rptr_g));

  p_dat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_take |=> $stable(req_dat_rptr_g) && $stable(cpl_dat_rptr_g));

  p_drain_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |=> $stable(req_hdr_rptr_g) && $stable(cpl_hdr_rptr_g)
                && $stable(req_dat_rptr_g) && $stable(cpl_dat_rptr_g));
endmodule

bind egtx_builder egtx_builder_chk #(.HI_W(HI_W), .DI_W(DI_W)) u_chk (.*);

// File: tb/egtx_builder_test.sv
module egtx_builder_test;
  localparam int HI_W = 5;
  localparam int DI_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drain_i = 1'b0;
  logic [HI_W:0] req_hdr_wptr_g, cpl_hdr_wptr_g, req_hdr_rptr_g, cpl_hdr_rptr_g, hbuf_addr;
  logic [DI_W:0] req_dat_wcnt, cpl_dat_wcnt, req_dat_rptr_g, cpl_dat_rptr_g, dbuf_addr;
  logic [131:0]  hbuf_rdata, dbuf_rdata;
  logic req_tx_valid, cpl_tx_valid, tx_start, tx_last, hdr_perr, dat_perr, drain_req;
  logic [7:0] tx_byte, tx_ctrl;

  logic [131:0] hmem [64];
  logic [131:0] dmem [256];

  int rh_w = 0, ch_w = 0, rd_w = 0, cd_w = 0, rd_pend = 0, cd_pend = 0;
  int checks = 0, errors = 0, cyc = 0, wd = 0;
  int exp_hperr = 0, exp_dperr = 0, seen_hperr = 0, seen_dperr = 0, seen_drain = 0;
  int last_end = 0, last_gap = 0;
  logic [17:0] qreq[$];
  logic [17:0] qcpl[$];
  bit order_log[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] gray_of(int v, int bits);
    logic [7:0] b, g;
    b = 8'(v % (1 << bits));
    for (int i = 0; i < 8; i++) g[i] = (i < 7) ? (b[i] ^ b[i+1]) : b[i];
    return g;
  endfunction

  function automatic logic [3:0] ref_par(logic [127:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) begin
      int ones = 0;
      for (int j = 0; j < 32; j++) ones += int'(d[32*i+j]);
      p[i] = (ones % 2 == 0);
    end
    return p;
  endfunction

  assign req_hdr_wptr_g = gray_of(rh_w, 6)[HI_W:0];
  assign cpl_hdr_wptr_g = gray_of(ch_w, 6)[HI_W:0];
  assign req_dat_wcnt   = 8'(rd_w % 256);
  assign cpl_dat_wcnt   = 8'(cd_w % 256);
  assign hbuf_rdata     = hmem[hbuf_addr];
  assign dbuf_rdata     = dmem[dbuf_addr];

  egtx_builder #(.HI_W(HI_W), .DI_W(DI_W)) uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit cpl, input logic [17:0] v);
    if (cpl) qcpl.push_back(v); else qreq.push_back(v);
  endtask

  task automatic add_pkt(input bit cpl, input bit four, input bit pay, input int len,
                         input bit ep, input bit bad_hdr, input int bad_ent, input bit hold);
    logic [127:0] h, d;
    logic [131:0] e;
    int hl, nent, nb, idx;
    bit tag, fin;
    h = {$urandom, $urandom, $urandom, $urandom};
    h[126] = pay; h[125] = four; h[110] = ep; h[105:96] = len[9:0];
    e = {ref_par(h), h};
    if (bad_hdr) e[128] = ~e[128];
    idx = cpl ? ch_w : rh_w;
    hmem[(cpl ? 0 : 32) + idx % 32] = e;
    hl = four ? 16 : 12;
    nent = pay ? (len / 4 + ((len % 4) != 0 ? 1 : 0)) : 0;
    tag = (bad_ent >= 0) && (bad_ent < nent) && !ep;
    if (bad_hdr) exp_hperr++;
    else begin
      push(cpl, {1'b1, 1'b0, 8'h00, 8'hFB});
      for (int k = 0; k < hl; k++) begin
        fin = (k == hl - 1) && (nent == 0);
        push(cpl, {1'b0, fin, fin ? 8'h02 : 8'h00, h[127-8*k -: 8]});
      end
      for (int en = 0; en < nent; en++) begin
        d = {$urandom, $urandom, $urandom, $urandom};
        e = {ref_par(d), d};
        if (en == bad_ent) e[129] = ~e[129];
        if (cpl) begin dmem[cd_pend % 128] = e; cd_pend++; end
        else begin dmem[128 + rd_pend % 128] = e; rd_pend++; end
        nb = (en == nent - 1 && (len % 4) != 0) ? (len % 4) * 4 : 16;
        for (int k = 0; k < nb; k++) begin
          fin = (en == nent - 1) && (k == nb - 1);
          push(cpl, {1'b0, fin, fin ? (tag ? 8'h12 : 8'h02) : 8'h00, d[127-8*k -: 8]});
        end
      end
      if (tag) exp_dperr++;
    end
    if (cpl) ch_w++; else rh_w++;
    if (!hold) begin rd_w = rd_pend; cd_w = cd_pend; end
  endtask

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (hdr_perr) seen_hperr++;
      if (dat_perr) seen_dperr++;
      if (drain_req) seen_drain++;
      if (req_tx_valid || cpl_tx_valid) begin
        logic [17:0] exp, act;
        string tag;
        bit p;
        p = cpl_tx_valid;
        act = {tx_start, tx_last, tx_ctrl, tx_byte};
        tag = tx_start ? "R5" : (tx_last ? "R9" : "R6");
        if ((p ? qcpl.size() : qreq.size()) == 0)
          chk(1'b0, tag, p ? "unexpected byte on completion port" : "unexpected byte on request port", 64'(act), 0);
        else begin
          exp = p ? qcpl.pop_front() : qreq.pop_front();
          chk(act == exp, tag, p ? "completion stream" : "request stream", 64'(act), 64'(exp));
        end
        if (tx_start) begin order_log.push_back(p); last_gap = cyc - last_end; end
        if (tx_last) last_end = cyc;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (qreq.size() == 0 && qcpl.size() == 0) break;
      tick(1);
    end
    tick(4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) hmem[i] = '0;
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    tick(5);
    #1;
    chk(!req_tx_valid && !cpl_tx_valid && !tx_start && !tx_last, "R1", "idle after reset", 64'({req_tx_valid, cpl_tx_valid, tx_start, tx_last}), 0);
    chk(!hdr_perr && !dat_perr && !drain_req, "R1", "no error pulse in reset", 64'({hdr_perr, dat_perr, drain_req}), 0);
    chk(req_hdr_rptr_g == 0 && cpl_hdr_rptr_g == 0 && req_dat_rptr_g == 0 && cpl_dat_rptr_g == 0, "R1", "pointers zero", 64'({req_hdr_rptr_g, cpl_hdr_rptr_g}), 0);
    rst_n = 1'b1;
    tick(3);

    // R5 R6 R4: both halves of the buffers in use, 3DW and 4DW headers, partial tail
    add_pkt(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);
    add_pkt(1'b1, 1'b1, 1'b1, 5, 1'b0, 1'b0, -1, 1'b0);
    add_pkt(1'b0, 1'b1, 1'b1, 3, 1'b0, 1'b0, -1, 1'b0);
    wait_idle();
    chk(qreq.size() == 0 && qcpl.size() == 0, "R6", "all bytes delivered", 64'(qreq.size() + qcpl.size()), 0);

    // R2 alternation with both queues busy
    order_log.delete();
    for (int i = 0; i < 2; i++) begin
      add_pkt(1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0, -1, 1'b0);
      add_pkt(1'b1, 1'b0, 1'b1, 6, 1'b0, 1'b0, -1, 1'b0);
    end
    wait_idle();
    chk(order_log.size() == 4, "R2", "packet count", 64'(order_log.size()), 4);
    for (int i = 1; i < order_log.size(); i++)
      chk(order_log[i] != order_log[i-1], "R2", "ports alternate", 64'(order_log[i]), 64'(!order_log[i-1]));

    // R2 empty completion turn still costs a cycle
    for (int i = 0; i < 3; i++) add_pkt(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);
    wait_idle();
    chk(last_gap == 3, "R2", "cycles from last byte to next start", 64'(last_gap), 3);

    // R8 header parity error, R10 parity sense
    add_pkt(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b1, -1, 1'b0);
    add_pkt(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);
    wait_idle();
    chk(seen_hperr == exp_hperr, "R8", "header parity pulses", 64'(seen_hperr), 64'(exp_hperr));
    chk(req_hdr_rptr_g == gray_of(rh_w, 6)[HI_W:0], "R8", "pointer advances past bad header", 64'(req_hdr_rptr_g), 64'(gray_of(rh_w, 6)));

    // R9 data parity: tagged when not poisoned, ignored when poisoned
    add_pkt(1'b0, 1'b0, 1'b1, 6, 1'b0, 1'b0, 1, 1'b0);
    add_pkt(1'b1, 1'b0, 1'b1, 8, 1'b1, 1'b0, 0, 1'b0);
    wait_idle();
    chk(seen_dperr == exp_dperr, "R9", "data parity pulses", 64'(seen_dperr), 64'(exp_dperr));
    chk(seen_drain == exp_hperr + exp_dperr, "R9", "drain requests", 64'(seen_drain), 64'(exp_hperr + exp_dperr));
    chk(exp_dperr == 1, "R10", "only the unpoisoned bad entry counts", 64'(exp_dperr), 1);

    // R7 stall on missing payload
    begin
      logic [DI_W:0] dp;
      dp = req_dat_rptr_g;
      add_pkt(1'b0, 1'b0, 1'b1, 8, 1'b0, 1'b0, -1, 1'b1);
      tick(40);
      chk(qreq.size() == 32, "R7", "bytes pending while stalled", 64'(qreq.size()), 32);
      chk(req_dat_rptr_g == dp, "R7", "data pointer held while stalled", 64'(req_dat_rptr_g), 64'(dp));
      rd_w = rd_pend;
      wait_idle();
      chk(qreq.size() == 0, "R7", "stream resumes after data arrives", 64'(qreq.size()), 0);
    end

    // R11 drain freezes service
    begin
      logic [HI_W:0] hp;
      drain_i = 1'b1;
      tick(2);
      hp = cpl_hdr_rptr_g;
      add_pkt(1'b1, 1'b0, 1'b1, 4, 1'b0, 1'b0, -1, 1'b0);
      tick(30);
      chk(qcpl.size() == 29, "R11", "no bytes while draining", 64'(qcpl.size()), 29);
      chk(cpl_hdr_rptr_g == hp, "R11", "header pointer held while draining", 64'(cpl_hdr_rptr_g), 64'(hp));
      drain_i = 1'b0;
      wait_idle();
      chk(qcpl.size() == 0, "R11", "packet sent after drain", 64'(qcpl.size()), 0);
    end

    // R3 header pointer wrap over more than the buffer depth
    for (int i = 0; i < 40; i++) begin
      add_pkt(1'b0, i[0], 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);
      wait_idle();
    end
    chk(req_hdr_rptr_g == gray_of(rh_w, 6)[HI_W:0], "R3", "request header pointer after wrap", 64'(req_hdr_rptr_g), 64'(gray_of(rh_w, 6)));
    chk(cpl_hdr_rptr_g == gray_of(ch_w, 6)[HI_W:0], "R3", "completion header pointer", 64'(cpl_hdr_rptr_g), 64'(gray_of(ch_w, 6)));
    chk(req_dat_rptr_g == gray_of(rd_w, 8), "R6", "request data pointer", 64'(req_dat_rptr_g), 64'(gray_of(rd_w, 8)));
    chk(cpl_dat_rptr_g == gray_of(cd_w, 8), "R6", "completion data pointer", 64'(cpl_dat_rptr_g), 64'(gray_of(cd_w, 8)));
    chk(seen_hperr == exp_hperr && seen_dperr == exp_dperr, "R8", "final error totals", 64'(seen_hperr + seen_dperr), 64'(exp_hperr + exp_dperr));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule